// File: doc/BRIEF.md
# Parity Bus Transceiver with Registered Error Flag

This block joins two byte-wide bus ports, called R and T, and moves a byte across in either direction. When the T port drives, the byte taken from the R port goes out with a parity bit generated on the fly. When the R port drives, the byte and parity bit taken from the T port pass through, and their parity is checked. Parity is odd: a correct nine-bit word holds an odd number of ones. One parity tree does both jobs. A steering stage chooses which byte and which parity bit feed the tree, according to the active direction.

Each rising clock edge stores the check result in a one-bit error register. That register drives an open-drain style error pin, modelled as an enable that pulls the line low while an error is held. An active-low clear input empties the register at once, with no clock needed. The two port enables are active-low. Asserting both at the same time is a diagnostic mode: the T port then sends the R byte with inverted parity, so a faulty word can be injected on purpose. Each tri-state port is modelled as a separate data output and a drive enable, with its own input.

Top module: `pbx_transceiver`

## Requirements
- R1: With oe_t_n=0 and oe_r_n=1, t_oe=1, r_oe=0, t_out equals r_in, and t_par_out makes the nine bits {t_out, t_par_out} hold an odd number of ones.
- R2: With oe_r_n=0 and oe_t_n=1, r_oe=1, t_oe=0, r_out equals t_in and r_par_out equals t_par_in.
- R3: With both enables high, t_oe=0 and r_oe=0, and t_out, t_par_out, r_out and r_par_out are all 0.
- R4: With both enables low, t_oe=1, r_oe=0, t_out equals r_in, and t_par_out is the inverse of the R1 parity, so {t_out, t_par_out} holds an even number of ones.
- R5: The checked word is {t_in, t_par_in} when oe_t_n=1, whatever the value of oe_r_n. When oe_t_n=0 it is {r_in, t_par_out}. An error is present when the checked word holds an even number of ones.
- R6: On every rising clk edge with clr_n=1, the error register loads the R5 result. err_oe (1 = pull the error line low) shows the stored value from that edge on and holds it until the next edge.
- R7: While clr_n=0, err_oe is 0 immediately, with no clock edge needed, and stays 0 through clock edges.
- R8: Normal transmission (oe_t_n=0, oe_r_n=1) never flags an error: the edge after such a cycle leaves err_oe=0. Diagnostic mode (both enables low) always leaves err_oe=1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error register |
| clr_n | input | 1 | Active-low asynchronous clear of the error register |
| oe_t_n | input | 1 | Active-low drive enable for the T port |
| oe_r_n | input | 1 | Active-low drive enable for the R port |
| r_in | input | DATA_W | Byte received on the R port |
| t_in | input | DATA_W | Byte received on the T port |
| t_par_in | input | 1 | Parity bit received on the T port |
| t_out | output | DATA_W | Byte driven onto the T port |
| t_par_out | output | 1 | Parity bit driven onto the T port |
| t_oe | output | 1 | T port drive enable (1 = driving) |
| r_out | output | DATA_W | Byte driven onto the R port |
| r_par_out | output | 1 | Parity bit driven onto the R port |
| r_oe | output | 1 | R port drive enable (1 = driving) |
| err_oe | output | 1 | Error pin pull-down enable (1 = error held, line low) |

## Verification
The properties assume that clk, the enables and the data inputs carry known 0/1 values whenever clr_n is high, and that clr_n changes away from a rising edge. The property for the error register also assumes that no input changes between the edge it samples and the next one. The stimulus applies every input one nanosecond after a rising edge and holds it for the whole cycle. It moves clr_n only in those windows, so every edge samples settled inputs. Directed patterns cover all four enable combinations, clears in mid-run and held errors. A run of pseudo-random words follows, using all four enable codes.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    // Transfer direction decoded from the two active-low enables {oe_t_n, oe_r_n}
    typedef enum logic [1:0] {
        PBX_DIAG = 2'b00,   // both enabled: R->T with inverted parity
        PBX_R2T  = 2'b01,   // T port drives R data
        PBX_T2R  = 2'b10,   // R port drives T data
        PBX_IDLE = 2'b11    // nobody drives
    } pbx_mode_e;

    // Registered state of the error flag
    typedef struct packed {
        logic flag;
    } pbx_err_s;

    // Steering decisions handed from the direction decoder
    typedef struct packed {
        logic tx_r2t;     // R byte travels toward T
        logic tx_t2r;     // T byte travels toward R
        logic inv_par;    // invert generated parity
    } pbx_ctrl_s;

endpackage

// File: rtl/pbx_dir_ctrl.sv
module pbx_dir_ctrl
    import pbx_pkg::*;
(
    input  logic      oe_t_n,
    input  logic      oe_r_n,
    output pbx_mode_e mode,
    output pbx_ctrl_s ctrl
);

    always_comb begin
        mode = pbx_mode_e'({oe_t_n, oe_r_n});
        ctrl = '0;
        unique case (mode)
            PBX_R2T:  ctrl.tx_r2t = 1'b1;
            PBX_T2R:  ctrl.tx_t2r = 1'b1;
            PBX_DIAG: begin
                ctrl.tx_r2t  = 1'b1;
                ctrl.inv_par = 1'b1;
            end
            default:  ctrl = '0;
        endcase
    end

endmodule

// File: rtl/pbx_parity_tree.sv
module pbx_parity_tree #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] bits,
    output logic             odd
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    // Leaves: real bits, zero padding beyond WIDTH
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < WIDTH) begin : g_bit
            assign node[LEAVES-1+i] = bits[i];
        end else begin : g_pad
            assign node[LEAVES-1+i] = 1'b0;
        end
    end

    // Internal XOR nodes, balanced binary tree
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_xor
        assign node[k] = node[2*k+1] ^ node[2*k+2];
    end

    assign odd = node[0];

endmodule

// File: rtl/pbx_steer.sv
module pbx_steer
    import pbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  pbx_ctrl_s         ctrl,
    input  logic [DATA_W-1:0] r_in,
    input  logic [DATA_W-1:0] t_in,
    input  logic              t_par_in,
    output logic [DATA_W:0]   tree_bits,
    input  logic              tree_odd,
    output logic              gen_par,
    output logic              err_now
);

    logic word_odd;

    // Select the byte and parity bit that feed the shared tree
    always_comb begin
        if (ctrl.tx_r2t) begin
            tree_bits = {r_in, 1'b0};        // parity slot empty while generating
        end else begin
            tree_bits = {t_in, t_par_in};    // check the incoming T word
        end
    end

    // Parity generation and check, both from the one tree result
    always_comb begin
        gen_par  = ~tree_odd ^ ctrl.inv_par;
        word_odd = tree_odd ^ (ctrl.tx_r2t ? gen_par : 1'b0);
        err_now  = ~word_odd;
    end

endmodule

// File: rtl/pbx_err_reg.sv
module pbx_err_reg
    import pbx_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic err_in,
    output logic flag
);

    pbx_err_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = err_in;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/pbx_transceiver.sv
module pbx_transceiver
    import pbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              oe_t_n,
    input  logic              oe_r_n,
    input  logic [DATA_W-1:0] r_in,
    input  logic [DATA_W-1:0] t_in,
    input  logic              t_par_in,
    output logic [DATA_W-1:0] t_out,
    output logic              t_par_out,
    output logic              t_oe,
    output logic [DATA_W-1:0] r_out,
    output logic              r_par_out,
    output logic              r_oe,
    output logic              err_oe
);

    localparam int TREE_W = DATA_W + 1;

    pbx_mode_e         mode;
    pbx_ctrl_s         ctrl;
    logic [TREE_W-1:0] tree_bits;
    logic              tree_odd;
    logic              gen_par;
    logic              err_now;
    logic              err_flag;

    pbx_dir_ctrl i_dir (
        .oe_t_n (oe_t_n),
        .oe_r_n (oe_r_n),
        .mode   (mode),
        .ctrl   (ctrl)
    );

    pbx_steer #(.DATA_W(DATA_W)) i_steer (
        .ctrl      (ctrl),
        .r_in      (r_in),
        .t_in      (t_in),
        .t_par_in  (t_par_in),
        .tree_bits (tree_bits),
        .tree_odd  (tree_odd),
        .gen_par   (gen_par),
        .err_now   (err_now)
    );

    pbx_parity_tree #(.WIDTH(TREE_W)) i_tree (
        .bits (tree_bits),
        .odd  (tree_odd)
    );

    pbx_err_reg i_err (
        .clk    (clk),
        .clr_n  (clr_n),
        .err_in (err_now),
        .flag   (err_flag)
    );

    // Port drivers: undriven ports present zeros
    always_comb begin
        t_out     = '0;
        t_par_out = 1'b0;
        t_oe      = 1'b0;
        r_out     = '0;
        r_par_out = 1'b0;
        r_oe      = 1'b0;
        if (ctrl.tx_r2t) begin
            t_out     = r_in;
            t_par_out = gen_par;
            t_oe      = 1'b1;
        end
        if (ctrl.tx_t2r) begin
            r_out     = t_in;
            r_par_out = t_par_in;
            r_oe      = 1'b1;
        end
    end

    assign err_oe = err_flag;

endmodule

// File: rtl/pbx_transceiver_chk.sv
module pbx_transceiver_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              oe_t_n,
    input logic              oe_r_n,
    input logic [DATA_W-1:0] r_in,
    input logic [DATA_W-1:0] t_in,
    input logic              t_par_in,
    input logic [DATA_W-1:0] t_out,
    input logic              t_par_out,
    input logic              t_oe,
    input logic [DATA_W-1:0] r_out,
    input logic              r_par_out,
    input logic              r_oe,
    input logic              err_oe
);

    // Port-level view of the checked word (R5), built from pins only
    logic exp_err;
    assign exp_err = oe_t_n ? ~(^{t_in, t_par_in}) : ~(^{t_out, t_par_out});

    p_r2t_odd_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (!oe_t_n && oe_r_n) |-> (t_oe && !r_oe && t_out == r_in && (^{t_out, t_par_out})));

    p_t2r_pass_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (oe_t_n && !oe_r_n) |-> (r_oe && !t_oe && r_out == t_in && r_par_out == t_par_in));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (oe_t_n && oe_r_n) |-> (!t_oe && !r_oe && t_out == '0 && r_out == '0));

    p_diag_even_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (!oe_t_n && !oe_r_n) |-> (t_oe && !r_oe && !(^{t_out, t_par_out})));

    p_err_capture_r6: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> (err_oe == $past(exp_err)));

    p_clear_r7: assert property (@(negedge clk)
        (clr_n == 1'b0) |-> !err_oe);

    p_tx_no_err_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (!oe_t_n && oe_r_n) |=> !err_oe);

endmodule

bind pbx_transceiver pbx_transceiver_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_pbx_transceiver.sv
`timescale 1ns/1ps
module test_pbx_transceiver;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         oe_t_n, oe_r_n;
    logic [W-1:0] r_in, t_in;
    logic         t_par_in;
    logic [W-1:0] t_out, r_out;
    logic         t_par_out, t_oe, r_par_out, r_oe, err_oe;

    int compared = 0;
    int mismatched = 0;
    int model_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pbx_transceiver #(.DATA_W(W)) i_pbx_transceiver (
        .clk(clk), .clr_n(clr_n), .oe_t_n(oe_t_n), .oe_r_n(oe_r_n),
        .r_in(r_in), .t_in(t_in), .t_par_in(t_par_in),
        .t_out(t_out), .t_par_out(t_par_out), .t_oe(t_oe),
        .r_out(r_out), .r_par_out(r_par_out), .r_oe(r_oe), .err_oe(err_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ones(input logic [W:0] v);
        return $countones(v);
    endfunction

    // One cycle: drive just after a rising edge, check before and after the next
    task automatic step(input logic [W-1:0] r, input logic [W-1:0] t,
                        input logic tp, input logic oet, input logic oer);
        int gp, e_err;
        r_in = r; t_in = t; t_par_in = tp; oe_t_n = oet; oe_r_n = oer;
        #3;
        gp = (ones({1'b0, r}) % 2 == 0) ? 1 : 0;
        if (!oet && oer) begin            // R1
            chk("R1 t_oe", t_oe, 1); chk("R1 r_oe", r_oe, 0);
            chk("R1 t_out", t_out, r); chk("R1 t_par", t_par_out, gp);
        end else if (oet && !oer) begin   // R2
            chk("R2 r_oe", r_oe, 1); chk("R2 t_oe", t_oe, 0);
            chk("R2 r_out", r_out, t); chk("R2 r_par", r_par_out, tp);
        end else if (oet && oer) begin    // R3
            chk("R3 oe", {t_oe, r_oe}, 0);
            chk("R3 data", {t_out, t_par_out, r_out, r_par_out}, 0);
        end else begin                    // R4
            chk("R4 t_oe", t_oe, 1); chk("R4 r_oe", r_oe, 0);
            chk("R4 t_out", t_out, r); chk("R4 t_par", t_par_out, 1 - gp);
        end
        chk("R6 hold", err_oe, model_err);
        // R5 reference: checked word and even-ones rule
        if (oet) e_err = (ones({t, tp}) % 2 == 0) ? 1 : 0;
        else     e_err = oer ? 0 : 1;
        @(posedge clk);
        #1;
        if (clr_n) model_err = e_err;
        chk("R5/R6 err", err_oe, model_err);
        if (clr_n && !oet && oer) chk("R8 tx no err", err_oe, 0);
        if (clr_n && !oet && !oer) chk("R8 diag err", err_oe, 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0; oe_t_n = 1'b1; oe_r_n = 1'b1;
        r_in = '0; t_in = '0; t_par_in = 1'b0;
        #3;
        chk("R7 reset", err_oe, 0);
        @(posedge clk); #1;
        chk("R7 reset held", err_oe, 0);
        clr_n = 1'b1;

        // Directed: each direction, good and bad parity
        step(8'hA5, 8'h00, 1'b0, 1'b0, 1'b1);   // R1, R8
        step(8'h01, 8'h00, 1'b0, 1'b0, 1'b1);
        step(8'h00, 8'h3C, 1'b1, 1'b1, 1'b0);   // R2, good odd word
        step(8'h00, 8'h3C, 1'b0, 1'b1, 1'b0);   // R2, error
        step(8'h00, 8'h3C, 1'b0, 1'b1, 1'b1);   // R3, idle keeps checking: error held
        step(8'hFF, 8'h80, 1'b0, 1'b1, 1'b1);   // R5 idle, odd word: clears
        step(8'h5A, 8'h00, 1'b0, 1'b0, 1'b0);   // R4 diag: error
        step(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);   // R4 diag zero byte
        step(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0);   // back to good

        // R7: asynchronous clear in mid-cycle with error held
        step(8'h00, 8'h0F, 1'b0, 1'b1, 1'b0);
        chk("R7 err before clear", err_oe, 1);
        clr_n = 1'b0; #1;
        model_err = 0;
        chk("R7 async clear", err_oe, 0);
        step(8'h00, 8'h0F, 1'b0, 1'b1, 1'b0);   // edge while clear held
        chk("R7 clear holds", err_oe, 0);
        clr_n = 1'b1;
        step(8'h00, 8'h0F, 1'b0, 1'b1, 1'b0);

        // Pseudo-random sweep over all enable codes
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] rr, tt;
            logic [1:0] en;
            logic pp;
            rr = W'($urandom); tt = W'($urandom);
            pp = 1'($urandom); en = 2'($urandom);
            step(rr, tt, pp, en[1], en[0]);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule